// File: doc/BRIEF.md
# Page Program Buffer with In-Page Wrap

This block sits behind the serial command interface of a flash-like memory and handles the data phase of a page write. A command opens with a strobe that carries the full byte address. The upper address bits choose the page and the low bits choose where the first byte lands. Data bytes then arrive one per valid strobe. They are held in an on-chip page buffer, together with a one-bit "loaded" flag for each offset. The write pointer moves forward inside the page and wraps back to offset 0 of the same page. It never carries into the next page. When a byte lands on an offset that already holds one, the new byte replaces the old one, so only the newest page's worth of data survives.

The command ends with a strobe sampled when chip select rises. This strobe carries a flag that tells whether the command ended on a whole byte. A program cycle starts only when that flag is set and at least one data byte was received. Otherwise the buffered data is dropped. During the program cycle the block reports busy for a fixed number of clock cycles. In the first part of that window it walks every offset of the page in ascending order, reads the current array byte and writes back the AND of that byte and the buffered byte, only at offsets that were loaded. Bits can therefore only move from 1 to 0. When the window ends, busy drops and a one-cycle done pulse goes to the status logic. Requests that arrive while busy are ignored.

Top module: `ppbuf_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done` and `arr_we` are all low.
- R2: The k-th data byte (k from 0) of a command is programmed at page offset (start offset + k) mod PAGE_SIZE, where the page is address bits [ADDR_W-1:PAGE_BITS] and the start offset is address bits [PAGE_BITS-1:0] of `start_addr`.
- R3: When the data runs past the last offset of the page, writing continues at offset 0 of the same page. The next page is never touched.
- R4: When more than PAGE_SIZE bytes arrive, each offset receives the last byte sent to it. Earlier bytes for that offset are discarded and not combined.
- R5: Offsets of the page that received no byte during the command keep their array contents.
- R6: Each programmed array byte becomes old AND new. A write never raises a bit from 0 to 1.
- R7: A program cycle starts only on `cmd_end` with `cmd_aligned`=1, after an accepted `start_valid` and at least one data byte. An end without alignment, without data or without an open command leaves the array unchanged and `busy` low.
- R8: `busy` rises in the cycle after the accepted `cmd_end` and stays high for exactly max(PROG_CYCLES, PAGE_SIZE) cycles. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R9: `start_valid`, `byte_valid` and `cmd_end` presented while `busy` is high are ignored. They neither lengthen the cycle nor start a second one, and they do not change the data programmed.
- R10: `arr_we` is asserted only while `busy` is high and only at addresses inside the selected page. The page address stays fixed for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_valid | input | 1 | Opens a program command and latches `start_addr` |
| start_addr | input | ADDR_W | Byte address of the first data byte |
| byte_valid | input | 1 | One data byte is present on `byte_data` |
| byte_data | input | 8 | Data byte |
| cmd_end | input | 1 | End of command (chip select rising) |
| cmd_aligned | input | 1 | Command ended on a byte boundary; sampled with `cmd_end` |
| arr_addr | output | ADDR_W | Array byte address during the page walk |
| arr_rdata | input | 8 | Current array byte at `arr_addr`, combinational |
| arr_we | output | 1 | Array write strobe |
| arr_wdata | output | 8 | Array write data (old AND buffered) |
| busy | output | 1 | Program cycle in progress |
| done | output | 1 | One-cycle pulse at the end of a program cycle |

## Verification
The bench builds the block with 8 address bits, 4-bit page offsets and a 40-cycle program time. That gives 16 pages of 16 bytes, and 40 cycles is longer than the 16-cycle walk. With these sizes every start offset can be swept against every byte count from 1 to more than twice the page size. This covers no wrap, a single wrap and multiple overwrites of the same offset. After each command the whole 256-byte array is compared against an AND model computed in the bench. The small page also keeps rejected endings and requests injected during the busy window cheap to run against every case.

// File: rtl/ppbuf_pkg.sv
// Shared types for the page program buffer.
package ppbuf_pkg;

    // Loader state: waiting for a command, or collecting its data bytes.
    typedef enum logic [0:0] {
        LD_IDLE = 1'b0,
        LD_OPEN = 1'b1
    } load_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/ppbuf_page_store.sv
// Page storage: one data byte and one loaded flag per page offset.
// Assumes: clear and wr_en are never asserted together (the loader
// guarantees it). Data bytes are not reset; only the flags are.
module ppbuf_page_store #(
    parameter int PAGE_BITS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       wr_en,
    input  logic [PAGE_BITS-1:0]       wr_off,
    input  logic [ppbuf_pkg::BYTE_W-1:0] wr_data,
    input  logic [PAGE_BITS-1:0]       rd_off,
    output logic [ppbuf_pkg::BYTE_W-1:0] rd_data,
    output logic                       rd_loaded
);
    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    logic [ppbuf_pkg::BYTE_W-1:0] bytes_q [PAGE_SIZE];
    logic [PAGE_SIZE-1:0]         loaded_q;

    // Loaded flags: cleared at command start, set by each byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= '0;
        end else if (clear) begin
            loaded_q <= '0;
        end else if (wr_en) begin
            loaded_q[wr_off] <= 1'b1;
        end
    end

    // Data bytes: a later byte for the same offset replaces the earlier one.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            bytes_q[wr_off] <= wr_data;
        end
    end

    assign rd_data   = bytes_q[rd_off];
    assign rd_loaded = loaded_q[rd_off];

endmodule

// File: rtl/ppbuf_load_ctrl.sv
// Command loader: latches page and start offset, steps the wrapping
// write pointer per data byte and decides whether the end of the
// command starts a program cycle.
// Assumes: start_valid is ignored while busy; cmd_end in the same
// cycle as byte_valid drops that byte.
module ppbuf_load_ctrl #(
    parameter int ADDR_W    = 19,
    parameter int PAGE_BITS = 8,
    localparam int PAGE_W   = ADDR_W - PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy,
    input  logic                 start_valid,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic                 byte_valid,
    input  logic                 cmd_end,
    input  logic                 cmd_aligned,
    output logic [PAGE_W-1:0]    page,
    output logic                 buf_clear,
    output logic                 buf_wr,
    output logic [PAGE_BITS-1:0] buf_off,
    output logic                 prog_start
);
    import ppbuf_pkg::*;

    load_state_e          state_q;
    logic [PAGE_BITS-1:0] ptr_q;
    logic [PAGE_W-1:0]    page_q;
    logic                 got_byte_q;
    logic                 open;
    logic                 take_start;

    assign open       = (state_q == LD_OPEN);
    assign take_start = start_valid && !busy;
    assign buf_clear  = take_start;
    assign buf_wr     = open && byte_valid && !cmd_end && !take_start;
    assign buf_off    = ptr_q;
    assign prog_start = open && cmd_end && cmd_aligned && got_byte_q && !take_start;
    assign page       = page_q;

    // Command state, page latch and in-page pointer that wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= LD_IDLE;
            ptr_q      <= '0;
            page_q     <= '0;
            got_byte_q <= 1'b0;
        end else if (take_start) begin
            state_q    <= LD_OPEN;
            page_q     <= start_addr[ADDR_W-1:PAGE_BITS];
            ptr_q      <= start_addr[PAGE_BITS-1:0];
            got_byte_q <= 1'b0;
        end else if (open && cmd_end) begin
            state_q    <= LD_IDLE;
        end else if (buf_wr) begin
            ptr_q      <= ptr_q + 1'b1;
            got_byte_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ppbuf_prog_timer.sv
// Program-cycle timer: holds busy for a fixed number of cycles, walks
// the page offsets in the first PAGE_SIZE of them and pulses done at
// the end.
// Assumes: prog_start is only seen while not busy.
module ppbuf_prog_timer #(
    parameter int PAGE_BITS   = 8,
    parameter int PROG_CYCLES = 300,
    localparam int PAGE_SIZE  = 1 << PAGE_BITS,
    localparam int HOLD       = (PROG_CYCLES < PAGE_SIZE) ? PAGE_SIZE : PROG_CYCLES,
    localparam int TIMER_W    = $clog2(HOLD + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prog_start,
    output logic                 busy,
    output logic                 done,
    output logic                 walk_en,
    output logic [PAGE_BITS-1:0] walk_off
);
    localparam logic [TIMER_W-1:0] LAST     = TIMER_W'(HOLD - 1);
    localparam logic [TIMER_W-1:0] PAGE_LIM = TIMER_W'(PAGE_SIZE);

    logic [TIMER_W-1:0] timer_q;
    logic               busy_q;
    logic               done_q;

    // Busy window counter with end-of-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            timer_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                if (timer_q == LAST) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    timer_q <= '0;
                end else begin
                    timer_q <= timer_q + 1'b1;
                end
            end else if (prog_start) begin
                busy_q  <= 1'b1;
                timer_q <= '0;
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign walk_en  = busy_q && (timer_q < PAGE_LIM);
    assign walk_off = timer_q[PAGE_BITS-1:0];

endmodule

// File: rtl/ppbuf_top.sv
// Page program buffer top: collects a command's data bytes into a
// wrapping page buffer, then ANDs the loaded bytes into the array
// during a timed program cycle.
// Assumes: arr_rdata returns the array byte at arr_addr in the same
// cycle; the array takes arr_wdata at the clock edge when arr_we is high.
module ppbuf_top #(
    parameter int ADDR_W      = 19,
    parameter int PAGE_BITS   = 8,
    parameter int PROG_CYCLES = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cmd_end,
    input  logic              cmd_aligned,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_rdata,
    output logic              arr_we,
    output logic [7:0]        arr_wdata,
    output logic              busy,
    output logic              done
);
    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    logic [PAGE_W-1:0]    page;
    logic                 buf_clear;
    logic                 buf_wr;
    logic [PAGE_BITS-1:0] buf_off;
    logic                 prog_start;
    logic                 walk_en;
    logic [PAGE_BITS-1:0] walk_off;
    logic [7:0]           buf_rd;
    logic                 buf_loaded;

    ppbuf_load_ctrl #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_load (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .start_valid (start_valid),
        .start_addr  (start_addr),
        .byte_valid  (byte_valid),
        .cmd_end     (cmd_end),
        .cmd_aligned (cmd_aligned),
        .page        (page),
        .buf_clear   (buf_clear),
        .buf_wr      (buf_wr),
        .buf_off     (buf_off),
        .prog_start  (prog_start)
    );

    ppbuf_page_store #(
        .PAGE_BITS (PAGE_BITS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (buf_clear),
        .wr_en     (buf_wr),
        .wr_off    (buf_off),
        .wr_data   (byte_data),
        .rd_off    (walk_off),
        .rd_data   (buf_rd),
        .rd_loaded (buf_loaded)
    );

    ppbuf_prog_timer #(
        .PAGE_BITS   (PAGE_BITS),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_start (prog_start),
        .busy       (busy),
        .done       (done),
        .walk_en    (walk_en),
        .walk_off   (walk_off)
    );

    // Array port: walk address in the latched page, write only loaded offsets.
    assign arr_addr  = {page, walk_off};
    assign arr_we    = walk_en && buf_loaded;
    assign arr_wdata = arr_rdata & buf_rd;

endmodule

// File: rtl/ppbuf_checker.sv
// Protocol checker for ppbuf_top, attached by bind below.
// Assumes: the same parameters as the bound instance.
module ppbuf_checker #(
    parameter int ADDR_W      = 19,
    parameter int PAGE_BITS   = 8,
    parameter int PROG_CYCLES = 300,
    localparam int PAGE_SIZE  = 1 << PAGE_BITS,
    localparam int HOLD       = (PROG_CYCLES < PAGE_SIZE) ? PAGE_SIZE : PROG_CYCLES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_end,
    input logic              cmd_aligned,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [7:0]        arr_rdata,
    input logic              arr_we,
    input logic [7:0]        arr_wdata,
    input logic              busy,
    input logic              done
);
    logic [31:0] run_len;

    // Length of the current busy run, counted independently of the timer.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= '0;
    end

    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 32'(HOLD)));

    assert_start_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_end && cmd_aligned));

    assert_write_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    assert_page_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:PAGE_BITS]));

    assert_clear_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ((arr_wdata & ~arr_rdata) == 8'h00));

endmodule

bind ppbuf_top ppbuf_checker #(
    .ADDR_W      (ADDR_W),
    .PAGE_BITS   (PAGE_BITS),
    .PROG_CYCLES (PROG_CYCLES)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_end     (cmd_end),
    .cmd_aligned (cmd_aligned),
    .arr_addr    (arr_addr),
    .arr_rdata   (arr_rdata),
    .arr_we      (arr_we),
    .arr_wdata   (arr_wdata),
    .busy        (busy),
    .done        (done)
);

// File: tb/ppbuf_top_test.sv
`timescale 1ns/1ps
module ppbuf_top_test;
    localparam int AW    = 8;
    localparam int PB    = 4;
    localparam int PC    = 40;
    localparam int PS    = 1 << PB;
    localparam int NPG   = 1 << (AW - PB);
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_valid = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          cmd_end = 1'b0;
    logic          cmd_aligned = 1'b0;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_rdata;
    logic          arr_we;
    logic [7:0]    arr_wdata;
    logic          busy;
    logic          done;

    logic [7:0] mem     [DEPTH];
    logic [7:0] exp_mem [DEPTH];

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    ppbuf_top #(.ADDR_W(AW), .PAGE_BITS(PB), .PROG_CYCLES(PC)) uut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .cmd_end(cmd_end),
        .cmd_aligned(cmd_aligned), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .arr_we(arr_we), .arr_wdata(arr_wdata), .busy(busy), .done(done)
    );

    // Array model: combinational read, write at the clock edge.
    assign arr_rdata = mem[arr_addr];
    always @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 151 + 17) | 8'hC3;
    endfunction

    function automatic logic [7:0] pat(int k, int seed);
        return 8'(k * 29 + seed * 7 + 3) ^ 8'h5A;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic reset_mem();
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]     = init_val(i);
            exp_mem[i] = init_val(i);
        end
    endtask

    task automatic compare_mem(string req);
        int bad = -1;
        for (int i = 0; i < DEPTH; i++)
            if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
        if (bad < 0) check(1'b1, req, "array", 0, 0);
        else check(1'b0, req, $sformatf("array byte %0h", bad), int'(mem[bad]), int'(exp_mem[bad]));
    endtask

    // Expected result: last byte per offset, ANDed into the old contents.
    task automatic apply_expected(int page, int s, int n, int seed);
        logic [7:0] last [PS];
        bit         hit  [PS];
        for (int o = 0; o < PS; o++) begin last[o] = 8'h00; hit[o] = 1'b0; end
        for (int k = 0; k < n; k++) begin
            last[(s + k) % PS] = pat(k, seed);
            hit[(s + k) % PS]  = 1'b1;
        end
        for (int o = 0; o < PS; o++)
            if (hit[o]) exp_mem[page * PS + o] = exp_mem[page * PS + o] & last[o];
    endtask

    task automatic send_cmd(int page, int s, int n, int seed, bit aligned, bit with_start);
        @(negedge clk);
        start_valid = with_start;
        start_addr  = AW'(page * PS + s);
        @(negedge clk);
        start_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            byte_valid = 1'b1;
            byte_data  = pat(k, seed);
            @(negedge clk);
        end
        byte_valid  = 1'b0;
        cmd_end     = 1'b1;
        cmd_aligned = aligned;
        @(negedge clk);
        cmd_end     = 1'b0;
        cmd_aligned = 1'b0;
    endtask

    task automatic wait_prog(output int len);
        len = 0;
        while (busy && len < 1000) begin
            len++;
            @(negedge clk);
        end
        check(done === 1'b1, "R8", "done at busy fall", int'(done), 1);
        @(negedge clk);
        check(done === 1'b0, "R8", "done one cycle", int'(done), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int t = 0;
        int len;
        reset_mem();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && arr_we === 1'b0, "R1", "outputs in reset",
              {busy, done, arr_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && arr_we === 1'b0, "R1", "outputs after reset",
              {busy, done, arr_we}, 0);

        // Sweep every start offset against byte counts up to past two pages.
        for (int s = 0; s < PS; s++) begin
            for (int n = 1; n <= 2 * PS + 3; n++) begin
                string req;
                int page = t % NPG;
                reset_mem();
                send_cmd(page, s, n, t, 1'b1, 1'b1);
                check(busy === 1'b1, "R7", "busy after aligned end", int'(busy), 1);
                wait_prog(len);
                check(len == PC, "R8", "busy length", len, PC);
                apply_expected(page, s, n, t);
                if (n > PS)          req = "R4 R6 R10";
                else if (s + n > PS) req = "R3 R5 R6 R10";
                else                 req = "R2 R5 R6 R10";
                compare_mem(req);
                t++;
            end
        end

        // Ends that must not program: unaligned, no data, no open command.
        for (int s = 0; s < 4; s++) begin
            for (int n = 0; n < 6; n++) begin
                reset_mem();
                send_cmd(s, s * 3, n, t, (n == 0), 1'b1);
                check(busy === 1'b0, "R7", "no busy on rejected end", int'(busy), 0);
                repeat (PS + 4) @(negedge clk);
                check(busy === 1'b0, "R7", "still idle", int'(busy), 0);
                compare_mem("R7");
                t++;
            end
        end
        reset_mem();
        send_cmd(2, 0, 4, t, 1'b1, 1'b0);
        check(busy === 1'b0, "R7", "end without start", int'(busy), 0);
        repeat (PS + 4) @(negedge clk);
        compare_mem("R7");

        // Requests during busy are ignored.
        for (int s = 0; s < PS; s += 5) begin
            int page = (s + 3) % NPG;
            reset_mem();
            send_cmd(page, s, 7, t, 1'b1, 1'b1);
            check(busy === 1'b1, "R9", "first cycle started", int'(busy), 1);
            send_cmd((page + 1) % NPG, 2, 3, t + 100, 1'b1, 1'b1);
            wait_prog(len);
            check(len + 6 == PC, "R9", "busy not extended", len + 6, PC);
            repeat (PC + 10) begin
                @(negedge clk);
                if (busy) break;
            end
            check(busy === 1'b0, "R9", "no second cycle", int'(busy), 0);
            apply_expected(page, s, 7, t);
            compare_mem("R9");
            t++;
        end

        finished = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule